// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block takes one burst request from a memory-mapped read or write address channel and expands it into the address of every data beat. A request gives the start address, a length field, a size field and a burst type. It is accepted through a valid/ready handshake. The block then offers one beat at a time on a valid/ready output. Each beat carries its byte address, a final-beat flag and an error flag. A beat is consumed only on a cycle where both `beat_valid` and `beat_ready` are high.

Back-pressure works as follows. `beat_valid` never waits for `beat_ready`. While `beat_ready` is low, the address, last flag and error flag hold their values. `req_ready` is high only when no burst is in progress. A request therefore waits until the cycle after the final beat of the previous burst has been consumed.

Requests that break the burst rules are still expanded into the requested number of beats, with `beat_err` held high for the whole burst. The block handles one burst at a time. Data, transaction IDs and responses are handled elsewhere.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `beat_valid` is low and `req_ready` is high. An asynchronous reset in the middle of a burst drops `beat_valid` at once.
- R2: `req_ready` is low from the cycle after a request is accepted until the cycle after the final beat is consumed. A request presented during that time has no effect on the beats.
- R3: The cycle after a request is accepted, `beat_valid` is high and `beat_addr` equals the start address exactly, aligned or not.
- R4: For burst type 2'b01 (incrementing), beat i > 0 has the address (start rounded down to a multiple of 2^size) + i·2^size. Here size is the log2 of the bytes per beat.
- R5: For burst type 2'b10 (wrapping) with a legal request, the addresses step by 2^size and wrap inside the aligned window of 2^size·(len+1) bytes that holds the start address.
- R6: A burst has len+1 beats, where len is the 8-bit length field (0 to 255). `beat_last` is high on the final beat and only on that beat. `beat_valid` falls the cycle after that beat is consumed.
- R7: While `beat_valid` is high and `beat_ready` is low, `beat_addr`, `beat_last` and `beat_err` stay unchanged.
- R8: An incrementing request whose final beat address lies in a different 4096-byte page from its start address sets `beat_err` for the whole burst.
- R9: A wrapping request is illegal in two cases: len is not 1, 3, 7 or 15, or the start is not a multiple of 2^size. Either case sets `beat_err`, and the burst is sequenced with incrementing addresses.
- R10: Burst type 2'b00 or 2'b11 sets `beat_err`, and the burst is sequenced with incrementing addresses.
- R11: An illegal request still produces exactly len+1 beats, with `beat_last` on the final one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Beat count minus one |
| req_size | input | SIZE_W | log2 of bytes per beat |
| req_burst | input | 2 | 01 incrementing, 10 wrapping, others illegal |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| beat_err | output | 1 | Current burst request was illegal |

## Verification
The bench aims at the cases where the address arithmetic tends to go wrong:
- An unaligned incrementing start. A design that keeps the offset after the first beat drifts off the size grid.
- A wrapping start in the middle of its window. A design with the wrong window mask leaves the window or wraps too early.
- Bursts that end exactly at a page edge, next to ones that cross it by one beat. An off-by-one in the final-address sum either flags a legal request or misses a crossing.
- Illegal wraps and illegal types. A design that stops early on these, or keeps wrapping, gives the wrong beat count or wrong addresses.
- Random stalls and requests pushed in mid-burst. A design that lets either one disturb the beat in flight is caught there.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    BT_RSVD0 = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD3 = 2'b11
  } burst_e;

  // Wrap lengths allowed: 2, 4, 8 or 16 beats (field value 1, 3, 7, 15)
  function automatic logic wrap_len_ok(input logic [7:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction
endpackage

// File: rtl/burst_req_check.sv
module burst_req_check
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int SIZE_W    = 3,
  parameter int PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  logic [1:0]        burst,
  output logic              illegal,
  output logic              wrap_ok,
  output logic [ADDR_W-1:0] wrap_mask
);
  localparam int PG_W = ADDR_W - PAGE_BITS + 1;

  logic [ADDR_W-1:0] lane_mask;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W:0]   final_ext;
  logic [PG_W-1:0]   first_pg, final_pg;
  logic              is_incr, is_wrap, bad_type, bad_page, bad_wlen, bad_walign;
  logic [7:0]        len8;

  assign len8      = 8'(len);
  assign lane_mask = (ADDR_W'(1) << size) - ADDR_W'(1);
  assign span      = ADDR_W'(len) << size;
  assign final_ext = {1'b0, addr & ~lane_mask} + {1'b0, span};
  assign first_pg  = {1'b0, addr[ADDR_W-1:PAGE_BITS]};
  assign final_pg  = final_ext[ADDR_W:PAGE_BITS];

  assign is_incr    = (burst == BT_INCR);
  assign is_wrap    = (burst == BT_WRAP);
  assign bad_type   = !is_incr && !is_wrap;
  assign bad_page   = is_incr && (first_pg != final_pg);
  assign bad_wlen   = is_wrap && !wrap_len_ok(len8);
  assign bad_walign = is_wrap && ((addr & lane_mask) != '0);

  assign illegal   = bad_type | bad_page | bad_wlen | bad_walign;
  assign wrap_ok   = is_wrap && !bad_wlen && !bad_walign;
  assign wrap_mask = ((ADDR_W'(len) + ADDR_W'(1)) << size) - ADDR_W'(1);
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              wrap_en,
  input  logic [ADDR_W-1:0] wrap_mask,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] lane_mask;
  logic [ADDR_W-1:0] stepped;

  assign lane_mask = (ADDR_W'(1) << size) - ADDR_W'(1);
  assign stepped   = (cur_addr & ~lane_mask) + (ADDR_W'(1) << size);
  assign next_addr = wrap_en ? ((cur_addr & ~wrap_mask) | (stepped & wrap_mask))
                             : stepped;
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic             advance,
  output logic             busy,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q, len_q;

  assign last = busy && (cnt_q == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      len_q <= len_in;
    end else if (advance) begin
      if (last) busy <= 1'b0;
      else      cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int SIZE_W    = 3,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [1:0]        req_burst,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last,
  output logic              beat_err
);
  logic              busy, last, req_fire, beat_fire;
  logic              illegal, wrap_ok, wrap_q;
  logic [ADDR_W-1:0] wmask, wmask_q, addr_q, addr_nxt;
  logic [SIZE_W-1:0] size_q;
  logic              err_q;

  assign req_ready  = !busy;
  assign req_fire   = req_valid && req_ready;
  assign beat_valid = busy;
  assign beat_fire  = busy && beat_ready;
  assign beat_addr  = addr_q;
  assign beat_last  = last;
  assign beat_err   = err_q;

  burst_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W),
                    .PAGE_BITS(PAGE_BITS)) u_check (
    .addr(req_addr), .len(req_len), .size(req_size), .burst(req_burst),
    .illegal(illegal), .wrap_ok(wrap_ok), .wrap_mask(wmask)
  );

  burst_addr_step #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_step (
    .cur_addr(addr_q), .size(size_q), .wrap_en(wrap_q),
    .wrap_mask(wmask_q), .next_addr(addr_nxt)
  );

  burst_beat_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(req_fire), .len_in(req_len),
    .advance(beat_fire), .busy(busy), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      wrap_q  <= 1'b0;
      wmask_q <= '0;
      err_q   <= 1'b0;
    end else if (req_fire) begin
      addr_q  <= req_addr;
      size_q  <= req_size;
      wrap_q  <= wrap_ok;
      wmask_q <= wmask;
      err_q   <= illegal;
    end else if (beat_fire && !last) begin
      addr_q  <= addr_nxt;
    end
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [SIZE_W-1:0] req_size,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              beat_last,
  input logic              beat_err
);
  logic [LEN_W-1:0]  c_cnt, c_len;
  logic [SIZE_W-1:0] c_size;
  logic [ADDR_W-1:0] c_mask;

  assign c_mask = (ADDR_W'(1) << c_size) - ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_cnt <= '0; c_len <= '0; c_size <= '0;
    end else if (req_valid && req_ready) begin
      c_cnt <= '0; c_len <= req_len; c_size <= req_size;
    end else if (beat_valid && beat_ready) begin
      c_cnt <= c_cnt + LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (!beat_valid && req_ready);
  end

  assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (beat_valid && beat_addr == $past(req_addr)));

  assert_later_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last) |=> ((beat_addr & c_mask) == '0));

  assert_last_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_last == (c_cnt == c_len)));

  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> (!beat_valid && req_ready));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr)
      && $stable(beat_last) && $stable(beat_err)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
  .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
  .beat_last(beat_last), .beat_err(beat_err)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int NV = 16;
  // {start addr, len, size, burst, expected err}
  localparam logic [45:0] VECS [0:NV-1] = '{
    {32'h0000_1000, 8'd3,   3'd2, 2'b01, 1'b0},
    {32'h0000_1003, 8'd2,   3'd2, 2'b01, 1'b0},
    {32'h0000_0FF8, 8'd0,   3'd3, 2'b01, 1'b0},
    {32'h0000_0FF8, 8'd1,   3'd3, 2'b01, 1'b1},
    {32'h0000_0FFC, 8'd1,   3'd2, 2'b01, 1'b1},
    {32'h0000_2008, 8'd3,   3'd2, 2'b10, 1'b0},
    {32'h0000_3030, 8'd7,   3'd3, 2'b10, 1'b0},
    {32'h0000_9016, 8'd15,  3'd1, 2'b10, 1'b0},
    {32'h0000_0100, 8'd2,   3'd2, 2'b10, 1'b1},
    {32'h0000_0102, 8'd1,   3'd2, 2'b10, 1'b1},
    {32'h0000_0500, 8'd0,   3'd2, 2'b10, 1'b1},
    {32'h0000_0040, 8'd1,   3'd0, 2'b00, 1'b1},
    {32'h0000_0080, 8'd2,   3'd1, 2'b11, 1'b1},
    {32'h0000_5000, 8'd255, 3'd0, 2'b01, 1'b0},
    {32'h0000_7000, 8'd255, 3'd4, 2'b01, 1'b0},
    {32'h0000_7001, 8'd255, 3'd4, 2'b01, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, beat_ready = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_burst = '0;
  logic        req_ready, beat_valid, beat_last, beat_err;
  logic [31:0] beat_addr;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  lfsr = 8'hA5;

  always #4 clk = ~clk;

  burst_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_last(beat_last), .beat_err(beat_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(input logic [31:0] st, input int len, input int sz,
                                             input logic [1:0] bt, input logic err, input int i);
    longint unsigned by, wb, base;
    by = longint'(1) << sz;
    if (bt == 2'b10 && !err) begin
      wb   = by * longint'(len + 1);
      base = st - (st % wb);
      return 32'(base + ((st - base + by * longint'(i)) % wb));
    end
    if (i == 0) return st;
    return 32'((st - (st % by)) + by * longint'(i));
  endfunction

  task automatic issue(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s, input logic [1:0] b);
    req_addr = a; req_len = l; req_size = s; req_burst = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [45:0] v, input bit stall);
    logic [31:0] st = v[45:14];
    int          len = int'(v[13:6]);
    int          sz = int'(v[5:3]);
    logic [1:0]  bt = v[2:1];
    logic        ee = v[0];
    string       etag, atag;
    bit          was_stall = 0;
    int          i = 0;
    etag = (bt == 2'b00 || bt == 2'b11) ? "R10" : (bt == 2'b10) ? "R9" : "R8";
    check(req_ready === 1'b1, "R2", {31'b0, req_ready}, 32'd1);
    issue(st, v[13:6], v[5:3], bt);
    while (i <= len) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      beat_ready = stall ? (lfsr[0] | lfsr[1]) : 1'b1;
      if (was_stall) atag = "R7";
      else if (bt == 2'b10 && !ee) atag = "R5";
      else if (ee) atag = etag;
      else atag = (i == 0) ? "R3" : "R4";
      check(beat_valid === 1'b1 && beat_addr === model_addr(st, len, sz, bt, ee, i),
            atag, beat_addr, model_addr(st, len, sz, bt, ee, i));
      check(beat_last === (i == len), ee ? "R11" : "R6", {31'b0, beat_last}, {31'b0, i == len});
      check(beat_err === ee, etag, {31'b0, beat_err}, {31'b0, ee});
      check(req_ready === 1'b0, "R2", {31'b0, req_ready}, 32'd0);
      was_stall = !beat_ready;
      @(negedge clk);
      if (beat_ready) i++;
    end
    beat_ready = 1'b0;
    check(beat_valid === 1'b0 && req_ready === 1'b1, ee ? "R11" : "R6",
          {30'b0, beat_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(beat_valid === 1'b0 && req_ready === 1'b1, "R1", {30'b0, beat_valid, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(beat_valid === 1'b0 && req_ready === 1'b1, "R1", {30'b0, beat_valid, req_ready}, 32'd1);

    for (int v = 0; v < NV; v++) run_vec(VECS[v], v[0]);

    // R2: a request offered mid-burst must not disturb the beats
    issue(32'h0000_0200, 8'd3, 3'd2, 2'b01);
    req_addr = 32'h0000_ABC0; req_len = 8'd9; req_burst = 2'b10; req_valid = 1'b1;
    for (int k = 0; k < 2; k++) begin
      check(req_ready === 1'b0 && beat_addr === 32'h200, "R2", beat_addr, 32'h200);
      @(negedge clk);
    end
    req_valid = 1'b0;
    beat_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      check(beat_addr === 32'h200 + 32'(4 * k), "R2", beat_addr, 32'h200 + 32'(4 * k));
      @(negedge clk);
    end
    beat_ready = 1'b0;
    check(beat_valid === 1'b0, "R2", {31'b0, beat_valid}, 32'd0);

    // R1: reset in the middle of a burst
    issue(32'h0000_0300, 8'd5, 3'd2, 2'b01);
    beat_ready = 1'b1;
    @(negedge clk);
    beat_ready = 1'b0;
    rst_n = 1'b0;
    #1;
    check(beat_valid === 1'b0 && req_ready === 1'b1, "R1", {30'b0, beat_valid, req_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(beat_valid === 1'b0 && req_ready === 1'b1, "R1", {30'b0, beat_valid, req_ready}, 32'd1);

    // R3: a fresh burst after reset starts at its own address
    run_vec({32'h0000_0444, 8'd1, 3'd2, 2'b01, 1'b0}, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule